// File: doc/BRIEF.md
# Dual-Slope Phase-Placed PWM Generator

This block is a symmetric up/down PWM timer with two waveform outputs. A counter rises from zero to a programmable turn-around value and then falls back to zero. Both end values are held for one tick each, so one period lasts `2*(TOP+1)` ticks. Each output has two compare values. The up-slope compare sets the output level and the down-slope compare clears it. This lets a pulse be placed anywhere in the period, rather than only centred on the turn-around point. Two outputs can therefore carry equal-duty waveforms shifted by a quarter period, or any other relative placement.

All configuration (turn-around value and the four compares) is taken from buffer inputs into shadow registers at the bottom turn-around, so a period never mixes old and new settings. A power-of-two prescaler derives the counting tick from the clock. Each output has a polarity bit that flips its sense. Dropping the enable returns the counter to zero counting up and parks both outputs at their inactive level.

Top module: `phase_pwm`

## Requirements
- R1: With `en` high, each tick moves the count 0,1,...,TOP,TOP,TOP-1,...,0,0,1,... The period is `2*(TOP+1)` ticks, so the output frequency is clk / (2 * 2^div_sel * (TOP+1)).
- R2: `div_sel = s` produces one tick every 2^s clocks. The first tick falls on the 2^s-th rising edge at which `en` is sampled high. Without a tick, the count and direction hold.
- R3: For output 0 with polarity 0, number the ticks from zero since enable and let p be the tick index modulo the period. The level is high after tick p exactly when `cmp_up0 <= p < 2*TOP+1-cmp_dn0`. It rises while counting up and falls while counting down.
- R4: Output 1 follows the same rule with `cmp_up1` (up-slope, set) and `cmp_dn1` (down-slope, clear).
- R5: `inv[i] = 1` inverts `pwm_o[i]`. Bit 0 belongs to output 0 and bit 1 to output 1.
- R6: Writes to `top_buf` and the four compare inputs during a run take effect only from the tick after the bottom turn-around. The period in progress keeps the old set. While `en` is low, the shadows follow the buffers every clock.
- R7: A compare greater than the active TOP never fires, and the level holds through that slope. A valid up compare without a valid down compare latches the level high for the rest of the run.
- R8: One edge after `en` is sampled low, the count is 0, the direction is up, the prescaler is cleared and `pwm_o == inv`. Re-enabling restarts the sequence from tick zero.
- R9: With TOP=19, up/down compares 14/4 on output 0 and 4/14 on output 1, and both polarities inverted, the two waveforms have equal shape. They are offset by 10 ticks (a quarter period).
- R10: While reset is asserted, the internal level registers are low, so `pwm_o == inv`. The asynchronous reset is released synchronously through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the timer |
| div_sel | input | SEL_W | Prescaler exponent, tick every 2^div_sel clocks |
| top_buf | input | CNT_W | Buffered turn-around value |
| cmp_up0 | input | CNT_W | Buffered up-slope (set) compare, output 0 |
| cmp_up1 | input | CNT_W | Buffered up-slope (set) compare, output 1 |
| cmp_dn0 | input | CNT_W | Buffered down-slope (clear) compare, output 0 |
| cmp_dn1 | input | CNT_W | Buffered down-slope (clear) compare, output 1 |
| inv | input | 2 | Per-output polarity invert |
| pwm_o | output | 2 | Waveform outputs |

## Verification
The level registers update on the same rising edge that processes a tick, so an output is due on that edge. The bench samples it at the following falling edge. After rising edge e of a run, it counts floor((e+1)/2^div_sel) processed ticks and evaluates the closed-form window of R3/R4 for that count. A buffer change is modelled as switching to the new set at tick index `2*(TOP_old+1)`, right after the bottom turn-around. The disable effect is checked one falling edge after `en` is sampled low.

// File: rtl/phase_pwm_pkg.sv
package phase_pwm_pkg;

  // Counting direction of the ramp.
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } ramp_dir_e;

  // Number of waveform outputs.
  localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/phase_pwm_prescale.sv
module phase_pwm_prescale #(
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);

  localparam int unsigned DIV_W = (1 << SEL_W) - 1;

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] pre_d;
  logic [DIV_W-1:0] wrap_mask;
  logic             pre_ce;

  // Terminal value is 2^div_sel - 1.
  assign wrap_mask = ~({DIV_W{1'b1}} << div_sel);
  assign tick      = en & (pre_q == wrap_mask);

  always_comb begin
    pre_ce = 1'b1;
    if (!en) begin
      pre_d = '0;
    end else if (tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (pre_ce) begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/phase_pwm_ramp.sv
module phase_pwm_ramp
  import phase_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [CW-1:0] top_buf,
  output logic [CW-1:0] cnt,
  output ramp_dir_e     dir,
  output logic [CW-1:0] top_sh,
  output logic          shadow_load
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] top_q, top_d;
  ramp_dir_e     dir_q, dir_d;
  logic          at_top;
  logic          at_bottom;
  logic          turn_bottom;
  logic          ramp_ce;

  assign at_top      = (cnt_q == top_q);
  assign at_bottom   = (cnt_q == '0);
  assign turn_bottom = tick & (dir_q == DIR_DN) & at_bottom;
  // Shadows track the buffers while idle and reload at the bottom turn.
  assign shadow_load = !en | turn_bottom;
  assign ramp_ce     = !en | tick;

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (!en) begin
      cnt_d = '0;
      dir_d = DIR_UP;
    end else if (tick) begin
      unique case (dir_q)
        DIR_UP: begin
          if (at_top) begin
            dir_d = DIR_DN;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        DIR_DN: begin
          if (at_bottom) begin
            dir_d = DIR_UP;
          end else begin
            cnt_d = cnt_q - 1'b1;
          end
        end
        default: begin
          dir_d = DIR_UP;
        end
      endcase
    end
  end

  always_comb begin
    top_d = top_q;
    if (shadow_load) begin
      top_d = top_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (ramp_ce) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
    end else if (shadow_load) begin
      top_q <= top_d;
    end
  end

  assign cnt    = cnt_q;
  assign dir    = dir_q;
  assign top_sh = top_q;

endmodule

// File: rtl/phase_pwm_chan.sv
module phase_pwm_chan
  import phase_pwm_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          shadow_load,
  input  ramp_dir_e     dir,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] up_buf,
  input  logic [CW-1:0] dn_buf,
  input  logic          inv,
  output logic          lvl,
  output logic          wave
);

  logic [CW-1:0] up_q, up_d;
  logic [CW-1:0] dn_q, dn_d;
  logic          lvl_q, lvl_d;
  logic          set_hit;
  logic          clr_hit;
  logic          lvl_ce;

  // A compare above the active TOP is never reached by cnt.
  assign set_hit = tick & (dir == DIR_UP) & (cnt == up_q);
  assign clr_hit = tick & (dir == DIR_DN) & (cnt == dn_q);
  assign lvl_ce  = !en | set_hit | clr_hit;

  always_comb begin
    lvl_d = lvl_q;
    if (!en) begin
      lvl_d = 1'b0;
    end else if (set_hit) begin
      lvl_d = 1'b1;
    end else if (clr_hit) begin
      lvl_d = 1'b0;
    end
  end

  always_comb begin
    up_d = up_q;
    dn_d = dn_q;
    if (shadow_load) begin
      up_d = up_buf;
      dn_d = dn_buf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else if (lvl_ce) begin
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q <= '0;
      dn_q <= '0;
    end else if (shadow_load) begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign lvl  = lvl_q;
  assign wave = lvl_q ^ inv;

endmodule

// File: rtl/phase_pwm.sv
module phase_pwm
  import phase_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic [CNT_W-1:0] top_buf,
  input  logic [CNT_W-1:0] cmp_up0,
  input  logic [CNT_W-1:0] cmp_up1,
  input  logic [CNT_W-1:0] cmp_dn0,
  input  logic [CNT_W-1:0] cmp_dn1,
  input  logic [1:0]       inv,
  output logic [1:0]       pwm_o
);

  logic                          rst_s0, rst_s1;
  logic                          rst_core_n;
  logic                          tick;
  logic [CNT_W-1:0]              cnt;
  logic [CNT_W-1:0]              top_sh;
  ramp_dir_e                     dir;
  logic                          going_dn;
  logic                          shadow_load;
  logic [NUM_CH-1:0][CNT_W-1:0]  up_vec;
  logic [NUM_CH-1:0][CNT_W-1:0]  dn_vec;
  logic [NUM_CH-1:0]             lvl;
  logic [NUM_CH-1:0]             wave;

  // Reset: asserted asynchronously, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s0 <= 1'b0;
      rst_s1 <= 1'b0;
    end else begin
      rst_s0 <= 1'b1;
      rst_s1 <= rst_s0;
    end
  end
  assign rst_core_n = rst_s1;

  // Fixed mapping: index 0 -> output 0, index 1 -> output 1.
  assign up_vec[0] = cmp_up0;
  assign up_vec[1] = cmp_up1;
  assign dn_vec[0] = cmp_dn0;
  assign dn_vec[1] = cmp_dn1;

  phase_pwm_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .en      (en),
    .div_sel (div_sel),
    .tick    (tick)
  );

  phase_pwm_ramp #(.CW(CNT_W)) u_ramp (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .en          (en),
    .tick        (tick),
    .top_buf     (top_buf),
    .cnt         (cnt),
    .dir         (dir),
    .top_sh      (top_sh),
    .shadow_load (shadow_load)
  );

  assign going_dn = (dir == DIR_DN);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    phase_pwm_chan #(.CW(CNT_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .en          (en),
      .tick        (tick),
      .shadow_load (shadow_load),
      .dir         (dir),
      .cnt         (cnt),
      .up_buf      (up_vec[gi]),
      .dn_buf      (dn_vec[gi]),
      .inv         (inv[gi]),
      .lvl         (lvl[gi]),
      .wave        (wave[gi])
    );
  end

  assign pwm_o = wave;

endmodule

// File: rtl/phase_pwm_chk.sv
module phase_pwm_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          tick,
  input logic [CW-1:0] cnt,
  input logic          going_dn,
  input logic [CW-1:0] top_sh,
  input logic [1:0]    lvl
);

  // R1
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top_sh);

  // R1
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !going_dn && (cnt != top_sh)) |=>
      (!going_dn && (cnt == $past(cnt) + 1'b1)));

  // R1
  top_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !going_dn && (cnt == top_sh)) |=>
      (going_dn && $stable(cnt)));

  // R1
  dn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && going_dn && (cnt != '0)) |=>
      (going_dn && (cnt == $past(cnt) - 1'b1)));

  // R2
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> ($stable(cnt) && $stable(going_dn)));

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(tick && going_dn && (cnt == '0))) |=> $stable(top_sh));

  // R3
  rise0_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl[0]) |-> !$past(going_dn));

  // R4
  rise1_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl[1]) |-> !$past(going_dn));

  // R3
  fall0_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl[0]) |-> ($past(going_dn) || !$past(en)));

  // R4
  fall1_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl[1]) |-> ($past(going_dn) || !$past(en)));

  // R8
  idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((cnt == '0) && !going_dn && (lvl == 2'b00)));

endmodule

bind phase_pwm phase_pwm_chk #(.CW(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_core_n),
  .en       (en),
  .tick     (tick),
  .cnt      (cnt),
  .going_dn (going_dn),
  .top_sh   (top_sh),
  .lvl      (lvl)
);

// File: tb/phase_pwm_tb.sv
`timescale 1ns/1ps
module phase_pwm_tb;

  localparam int CW = 16;
  localparam int SW = 3;

  logic          clk;
  logic          rst_n;
  logic          en;
  logic [SW-1:0] div_sel;
  logic [CW-1:0] top_buf, cmp_up0, cmp_up1, cmp_dn0, cmp_dn1;
  logic [1:0]    inv;
  logic [1:0]    pwm_o;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  phase_pwm #(.CNT_W(CW), .SEL_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
    .top_buf(top_buf), .cmp_up0(cmp_up0), .cmp_up1(cmp_up1),
    .cmp_dn0(cmp_dn0), .cmp_dn1(cmp_dn1), .inv(inv), .pwm_o(pwm_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  // Raw level after tick index n (n < 0: no tick yet), from the R3 window.
  function automatic bit exp_lvl(input int n, input int top, input int cu, input int cd);
    int  per, p, pd;
    bit  uv, dv;
    if (n < 0) return 1'b0;
    per = 2 * (top + 1);
    p   = n % per;
    uv  = (cu <= top);
    dv  = (cd <= top);
    pd  = 2 * top + 1 - cd;
    if (uv && dv) return (p >= cu) && (p < pd);
    if (uv)       return (n >= cu);          // R7 latch high
    return 1'b0;
  endfunction

  task automatic set_bufs(input int t, input int u0, input int d0, input int u1, input int d1);
    top_buf = CW'(t);
    cmp_up0 = CW'(u0);
    cmp_dn0 = CW'(d0);
    cmp_up1 = CW'(u1);
    cmp_dn1 = CW'(d1);
  endtask

  // One run: set A while idle, enable, optionally write set B after edge sw_e.
  task automatic run(input string tag, input int sel,
                     input int ta, input int ua0, input int da0, input int ua1, input int da1,
                     input int tb, input int ub0, input int db0, input int ub1, input int db1,
                     input int sw_e, input logic [1:0] iv, input int ncyc);
    int pa;
    @(negedge clk);
    en      = 1'b0;
    div_sel = SW'(sel);
    inv     = iv;
    set_bufs(ta, ua0, da0, ua1, da1);
    repeat (3) @(negedge clk);
    // R8: parked at inactive level
    chk(pwm_o == iv, {tag, " R8 idle level"}, int'(pwm_o), int'(iv));
    en = 1'b1;
    pa = 2 * (ta + 1);
    for (int e = 0; e < ncyc; e++) begin
      int  n;
      bit  x0, x1;
      @(negedge clk);
      n = ((e + 1) >> sel) - 1;
      if (sw_e < 0 || n < pa) begin
        x0 = exp_lvl(n, ta, ua0, da0);
        x1 = exp_lvl(n, ta, ua1, da1);
      end else begin
        x0 = exp_lvl(n - pa, tb, ub0, db0);
        x1 = exp_lvl(n - pa, tb, ub1, db1);
      end
      chk(pwm_o[0] == (x0 ^ iv[0]), {tag, " out0"}, int'(pwm_o[0]), int'(x0 ^ iv[0]));
      chk(pwm_o[1] == (x1 ^ iv[1]), {tag, " out1"}, int'(pwm_o[1]), int'(x1 ^ iv[1]));
      if (e == sw_e) set_bufs(tb, ub0, db0, ub1, db1);
    end
  endtask

  initial begin
    rst_n   = 1'b0;
    en      = 1'b0;
    div_sel = '0;
    inv     = 2'b10;
    set_bufs(5, 1, 1, 2, 2);
    repeat (3) @(negedge clk);
    // R10: reset holds levels low
    chk(pwm_o == 2'b10, "R10 reset level", int'(pwm_o), 2);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 quarter-period offset, inverted polarity
    run("R9 R3 R4", 0, 19,14,4,4,14, 19,14,4,4,14, -1, 2'b11, 130);
    // R5 same placement, plain polarity
    run("R5 R1", 0, 19,14,4,4,14, 19,14,4,4,14, -1, 2'b00, 90);
    // R2 prescaler by 2
    run("R2 R3", 1, 5,2,2,0,5, 5,2,2,0,5, -1, 2'b01, 80);
    // R2 prescaler by 4
    run("R2 R4", 2, 3,3,0,1,3, 3,3,0,1,3, -1, 2'b10, 90);
    // R2 prescaler by 8
    run("R2 R1", 3, 2,1,2,0,1, 2,1,2,0,1, -1, 2'b00, 150);
    // R7 out-of-range compares
    run("R7", 0, 6,9,3,2,7, 6,9,3,2,7, -1, 2'b00, 60);
    // R7 both out of range on out0
    run("R7 R5", 0, 4,5,6,0,0, 4,5,6,0,0, -1, 2'b01, 40);
    // R1 smallest TOP
    run("R1 R3", 0, 0,0,0,1,0, 0,0,0,1,0, -1, 2'b00, 20);
    // R6 buffer change mid-period, shorter TOP
    run("R6", 0, 7,2,5,6,1, 4,1,1,3,0, 3, 2'b00, 80);
    // R6 longer TOP under prescaler
    run("R6 R2", 1, 4,1,3,3,0, 9,8,2,0,9, 2, 2'b10, 120);
    // R8 restart: re-run a config after a disable
    run("R8 R1", 0, 7,2,5,6,1, 7,2,5,6,1, -1, 2'b01, 40);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule